// File: doc/BRIEF.md
# Data-Path Status and Strobe Register Pair

This block sits between a host register bus and the byte stream of a serial peripheral link. It holds two byte queues. The receive queue carries bytes from the link to the host. The transmit queue carries bytes from the host to the link. Two 8-bit registers sit on the host bus.

The first register is a status/control word. On read it gathers three external indications: board presence, a processed time-code pulse-per-second, and a direct modem pulse-per-second. It also reports four queue flags, one of which is a sticky receive-overflow flag. On write, only bit 0 matters. Writing a value of bit 0 that differs from the last value written starts a one-cycle flush of the whole data path.

The second register is write-only. A write to it with any data value discards the oldest receive byte. That oldest byte is always visible on a separate head output, so the host reads it first and then strobes it away.

Top module: `spi_path_regs`

## Requirements
- R1: After reset both queues are empty, the overflow flag is clear and the remembered control bit is 0, so a first write of 0 to bit 0 causes no flush.
- R2: A read at address 0x6E returns bit 7 = board_present, bit 6 = tc_pps, bit 5 = modem_pps, bit 4 = 0, bit 3 = transmit queue empty, bit 2 = transmit queue full, bit 1 = receive queue empty, bit 0 = receive overflow.
- R3: Reads at address 0x6F, and at any address other than 0x6E, return 0.
- R4: A write to 0x6F, whatever its data, removes the oldest receive byte. When the receive queue is empty the write has no effect.
- R5: A write to 0x6E whose bit 0 differs from the bit 0 of the previous such write raises an internal flush for exactly the next cycle. A write with an unchanged bit 0 does nothing, and bits 7..1 of the written data are ignored.
- R6: A receive push that arrives while the receive queue is full is dropped and sets the overflow flag. The flag stays set, across pops, until the next flush.
- R7: A flush empties both queues and clears the overflow flag. A push presented during the flush cycle is dropped.
- R8: rx_head shows the oldest receive byte and tx_head shows the oldest transmit byte. Each reads 0 while its queue is empty.
- R9: The transmit queue returns bytes in push order. A pop while it is empty is ignored, and a push while it is full is dropped without raising any flag.
- R10: On a non-empty queue, a push and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register bus address |
| reg_wr | input | 1 | Register bus write enable |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data (combinational on address) |
| rx_push | input | 1 | Link side: push a received byte |
| rx_data | input | 8 | Link side: received byte |
| rx_head | output | 8 | Oldest byte of the receive queue |
| tx_push | input | 1 | Host side: push a byte to send |
| tx_data | input | 8 | Host side: byte to send |
| tx_pop | input | 1 | Link side: consume the oldest transmit byte |
| tx_head | output | 8 | Oldest byte of the transmit queue |
| board_present | input | 1 | Board presence indication |
| tc_pps | input | 1 | Processed time-code pulse-per-second seen |
| modem_pps | input | 1 | Direct modem pulse-per-second seen |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a link-side receive push and a host strobe. The second pair is a flush and a push that arrives during it. The bench provokes the first pair by driving rx_push and a 0x6F write on the same edge of a non-empty queue, and it judges the result by a head that advanced while the queue stayed non-empty. It provokes the second pair by pushing in the cycle right after a toggling control write, and it judges the result by an empty receive flag and a zero head afterwards.

// File: rtl/spi_path_pkg.sv
package spi_path_pkg;

    localparam logic [7:0] ADDR_STATUS = 8'h6E;
    localparam logic [7:0] ADDR_STROBE = 8'h6F;

    localparam int BIT_BOARD  = 7;
    localparam int BIT_TC_PPS = 6;
    localparam int BIT_MD_PPS = 5;
    localparam int BIT_RSVD   = 4;
    localparam int BIT_TX_EMP = 3;
    localparam int BIT_TX_FUL = 2;
    localparam int BIT_RX_EMP = 1;
    localparam int BIT_RX_OVF = 0;

    typedef struct packed {
        logic ctl_bit;
        logic flush;
        logic ovf;
    } ctrl_state_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CAP);
    assign head  = empty ? '0 : mem_q[st_q.rd];

    always_comb begin
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = bump(st_q.wr);
            if (do_pop)  st_d.rd = bump(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

endmodule

// File: rtl/spi_path_ctrl.sv
module spi_path_ctrl
    import spi_path_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       rx_push,
    input  logic       rx_full,
    output logic       flush,
    output logic       strobe,
    output logic       ovf
);
    ctrl_state_t st_d, st_q;
    logic ctl_wr;

    assign ctl_wr = reg_wr && (reg_addr == ADDR_STATUS);
    assign strobe = reg_wr && (reg_addr == ADDR_STROBE);
    assign flush  = st_q.flush;
    assign ovf    = st_q.ovf;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (ctl_wr) begin
            st_d.ctl_bit = reg_wdata[0];
            st_d.flush   = (reg_wdata[0] != st_q.ctl_bit);
        end
        if (st_q.flush)                st_d.ovf = 1'b0;
        else if (rx_push && rx_full)   st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/spi_path_regs.sv
module spi_path_regs
    import spi_path_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] rx_head,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_head,
    input  logic              board_present,
    input  logic              tc_pps,
    input  logic              modem_pps
);
    logic flush_w, strobe_w, ovf_w;
    logic rx_empty, rx_full, tx_empty, tx_full;

    spi_path_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .rx_push   (rx_push),
        .rx_full   (rx_full),
        .flush     (flush_w),
        .strobe    (strobe_w),
        .ovf       (ovf_w)
    );

    spi_byte_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_w),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (strobe_w),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    spi_byte_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_w),
        .push      (tx_push),
        .push_data (tx_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STATUS) begin
            reg_rdata[BIT_BOARD]  = board_present;
            reg_rdata[BIT_TC_PPS] = tc_pps;
            reg_rdata[BIT_MD_PPS] = modem_pps;
            reg_rdata[BIT_RSVD]   = 1'b0;
            reg_rdata[BIT_TX_EMP] = tx_empty;
            reg_rdata[BIT_TX_FUL] = tx_full;
            reg_rdata[BIT_RX_EMP] = rx_empty;
            reg_rdata[BIT_RX_OVF] = ovf_w;
        end
    end

endmodule

// File: rtl/spi_path_regs_chk.sv
module spi_path_regs_chk
    import spi_path_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       rx_push,
    input logic       flush,
    input logic       strobe,
    input logic       ovf,
    input logic       rx_empty,
    input logic       rx_full,
    input logic       tx_empty,
    input logic       tx_full
);
    // R2: the reserved position never reads 1
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STATUS) |-> (reg_rdata[BIT_RSVD] == 1'b0));

    // R5: a flush cycle is always preceded by a control write
    a_r5_flush_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush) |-> $past(reg_wr && (reg_addr == ADDR_STATUS)));

    // R4: a strobe on an empty queue leaves it empty
    a_r4_strobe_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && rx_empty && !rx_push) |=> rx_empty);

    // R6: overflow is set by a push into a full queue and held
    a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !flush) |=> ovf);
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);

    // R7: a flush leaves both queues empty and overflow clear
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_empty && tx_empty && !ovf));

    // R9: a queue is never empty and full at once
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full) && !(tx_empty && tx_full));

endmodule

bind spi_path_regs spi_path_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .rx_push   (rx_push),
    .flush     (flush_w),
    .strobe    (strobe_w),
    .ovf       (ovf_w),
    .rx_empty  (rx_empty),
    .rx_full   (rx_full),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full)
);

// File: tb/spi_path_regs_tb.sv
module spi_path_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam logic [7:0] A_STAT = 8'h6E;
    localparam logic [7:0] A_STRB = 8'h6F;

    // op: 0 idle, 1 rx push, 2 strobe, 3 control write, 4 tx push
    // entry: {op[3:0], data[7:0], expected status[7:0], expected rx_head[7:0]}
    localparam int NVEC = 23;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd0, 8'h00, 8'hAA, 8'h00},
        {4'd1, 8'h11, 8'hA8, 8'h11},
        {4'd1, 8'h22, 8'hA8, 8'h11},
        {4'd2, 8'h5A, 8'hA8, 8'h22},
        {4'd2, 8'h5A, 8'hAA, 8'h00},
        {4'd2, 8'h5A, 8'hAA, 8'h00},
        {4'd1, 8'h33, 8'hA8, 8'h33},
        {4'd1, 8'h44, 8'hA8, 8'h33},
        {4'd1, 8'h55, 8'hA8, 8'h33},
        {4'd1, 8'h66, 8'hA8, 8'h33},
        {4'd1, 8'h77, 8'hA9, 8'h33},
        {4'd4, 8'h01, 8'hA1, 8'h33},
        {4'd4, 8'h02, 8'hA1, 8'h33},
        {4'd4, 8'h03, 8'hA1, 8'h33},
        {4'd4, 8'h04, 8'hA5, 8'h33},
        {4'd3, 8'h01, 8'hA5, 8'h33},
        {4'd0, 8'h00, 8'hAA, 8'h00},
        {4'd3, 8'h01, 8'hAA, 8'h00},
        {4'd1, 8'h88, 8'hA8, 8'h88},
        {4'd3, 8'hFF, 8'hA8, 8'h88},
        {4'd0, 8'h00, 8'hA8, 8'h88},
        {4'd3, 8'h00, 8'hA8, 8'h88},
        {4'd0, 8'h00, 8'hAA, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = A_STAT;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic [7:0] rx_head;
    logic       tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_head;
    logic       board_present = 1'b1;
    logic       tc_pps = 1'b0;
    logic       modem_pps = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_path_regs #(.DATA_W(8), .RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_push(rx_push), .rx_data(rx_data), .rx_head(rx_head),
        .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_head(tx_head),
        .board_present(board_present), .tc_pps(tc_pps), .modem_pps(modem_pps)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_addr = A_STAT; reg_wdata = '0;
        rx_push = 1'b0; tx_push = 1'b0; tx_pop = 1'b0;
    endtask

    // drive for one edge, then release and settle for sampling
    task automatic apply(input logic [3:0] op, input logic [7:0] d);
        @(negedge clk);
        case (op)
            4'd1: begin rx_push = 1'b1; rx_data = d; end
            4'd2: begin reg_wr = 1'b1; reg_addr = A_STRB; reg_wdata = d; end
            4'd3: begin reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = d; end
            4'd4: begin tx_push = 1'b1; tx_data = d; end
            4'd5: tx_pop = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 / R2 reset state: 0xA0 inputs plus both empty flags
        check("R1 reset status", reg_rdata, 8'hAA);
        check("R8 reset rx_head", rx_head, 8'h00);
        check("R8 reset tx_head", tx_head, 8'h00);
        reg_addr = A_STRB; #1;
        check("R3 strobe reg reads 0", reg_rdata, 8'h00);
        reg_addr = 8'h12; #1;
        check("R3 other addr reads 0", reg_rdata, 8'h00);
        reg_addr = A_STAT;
        board_present = 1'b0; tc_pps = 1'b1; modem_pps = 1'b0; #1;
        check("R2 status input bits", reg_rdata, 8'h4A);
        board_present = 1'b1; tc_pps = 1'b0; modem_pps = 1'b1; #1;

        // table walk: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][27:24], VEC[i][23:16]);
            check($sformatf("R2/R4/R5/R6/R7 status step %0d", i), reg_rdata, VEC[i][15:8]);
            check($sformatf("R8 rx_head step %0d", i), rx_head, VEC[i][7:0]);
        end

        // R9 transmit order, pop when empty, push when full dropped
        apply(4'd4, 8'hA1);
        apply(4'd4, 8'hB2);
        check("R8 tx_head first", tx_head, 8'hA1);
        apply(4'd5, 8'h00);
        check("R9 tx order second", tx_head, 8'hB2);
        apply(4'd5, 8'h00);
        check("R9 tx empty after pops", reg_rdata, 8'hAA);
        apply(4'd5, 8'h00);
        check("R9 tx pop on empty ignored", tx_head, 8'h00);
        for (int k = 0; k < DEPTH + 1; k++) apply(4'd4, 8'hC0 + 8'(k));
        check("R9 tx full no flag", reg_rdata, 8'hA6);
        for (int k = 0; k < DEPTH; k++) apply(4'd5, 8'h00);
        check("R9 tx extra push dropped", reg_rdata, 8'hAA);

        // R10 push and strobe in the same cycle
        apply(4'd1, 8'h10);
        @(negedge clk);
        rx_push = 1'b1; rx_data = 8'h20;
        reg_wr = 1'b1; reg_addr = A_STRB; reg_wdata = 8'h00;
        @(negedge clk);
        idle_inputs(); #1;
        check("R10 rx head after push+pop", rx_head, 8'h20);
        check("R10 rx not empty", reg_rdata, 8'hA8);
        apply(4'd2, 8'hFF);
        check("R4 strobe any data empties", reg_rdata, 8'hAA);

        // R7 push during the flush cycle is dropped (control bit 0 -> 1)
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0; rx_push = 1'b1; rx_data = 8'h99;
        @(negedge clk);
        idle_inputs(); #1;
        check("R7 push in flush dropped", reg_rdata, 8'hAA);
        check("R7 rx_head zero after flush", rx_head, 8'h00);

        // R6 overflow survives a pop, cleared by flush (control bit 1 -> 0)
        for (int k = 0; k < DEPTH + 1; k++) apply(4'd1, 8'h50 + 8'(k));
        check("R6 overflow set", reg_rdata, 8'hA9);
        apply(4'd2, 8'h00);
        check("R6 overflow sticky after pop", reg_rdata, 8'hA9);
        check("R6 dropped byte not stored", rx_head, 8'h51);
        apply(4'd3, 8'h00);
        apply(4'd0, 8'h00);
        check("R7 flush clears overflow", reg_rdata, 8'hAA);

        // R1 reset mid-run, then control bit remembered as 0
        apply(4'd1, 8'h61);
        apply(4'd3, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears status", reg_rdata, 8'hAA);
        @(negedge clk);
        rst_n = 1'b1;
        apply(4'd1, 8'h62);
        apply(4'd3, 8'h00);
        apply(4'd0, 8'h00);
        check("R1 ctl bit 0 after reset no flush", rx_head, 8'h62);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    end

endmodule